// File: doc/BRIEF.md
# Raster Timing Generator with Variable Line Lengths

This block keeps the horizontal and vertical position of a video raster. It advances once per master clock. It turns the clock count into a dot index, using dots that are normally four clocks wide and a few that are five clocks wide. It also supplies the blanking and active-picture flags that downstream video and memory-arbitration logic use. Three per-frame settings shape the raster:

- a region select, which picks the shorter or the taller frame;
- an interlace enable, which adds one line on every even field;
- a tall-picture (overscan) select, which moves the start of vertical blanking down.

Line lengths are not uniform. Two single-line exceptions keep the raster locked to the colour subcarrier:

- One shortened line has no five-clock dots.
- One lengthened line has one extra four-clock dot.

The three settings are captured only when the raster wraps back to the top of a frame. A frame in progress therefore never mixes rules. Every output is a plain level or strobe, with no handshake. Consumers sample the outputs every clock.

Top module: `raster_timing_gen`

## Requirements
- R1: While rst_n is low, h_clk, dot_idx, v_line, field, vblank, active and frame_start are all 0. The captured settings return to: short-frame region, interlace off, normal picture height.
- R2: A normal line lasts LINE_DOTS*DOT_CLKS+WIDE_CNT clocks (default 1364). It has LINE_DOTS dots (default 340). Dots WIDE_FIRST to WIDE_FIRST+WIDE_CNT-1 (default 323 to 326) are DOT_CLKS+1 clocks wide, and every other dot is DOT_CLKS clocks wide. Within a line, h_clk rises by one each clock from 0.
- R3: The shortened line happens only when the region is short-frame (pal_mode=0), interlace is off, field=1 and v_line=SHORT_LINE (default 240). It lasts LINE_DOTS*DOT_CLKS clocks (default 1360), with LINE_DOTS dots that are all DOT_CLKS wide.
- R4: The lengthened line happens only when the region is long-frame (pal_mode=1), interlace is on, field=1 and v_line=PAL_LAST (default 311). It lasts the normal length plus DOT_CLKS (default 1368), with LINE_DOTS+1 dots. The extra last dot is DOT_CLKS wide, and the wide dots keep their positions.
- R5: The last line of a frame is NTSC_LAST (default 261) when pal_mode=0 and PAL_LAST (default 311) when pal_mode=1. When interlace is on and field=0, one more line is added. After the last line, v_line returns to 0.
- R6: field starts at 0 and inverts at every frame wrap. frame_start is high for exactly the first clock of each frame, when h_clk=0 and v_line=0. It is not raised by reset release.
- R7: vblank is high when v_line is at or above VBL_START (default 225), or VBL_START_TALL (default 240) when overscan is captured, up to the last line. It is low on every other line, line 0 included.
- R8: active is high only when 1 <= v_line < the vblank start line and ACT_H_FIRST <= h_clk < ACT_H_END (default 88 and 1112).
- R9: pal_mode, interlace_en and overscan_en are captured only at a frame wrap. A change during a frame has no effect until the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_mode | input | 1 | Region select: 0 short frame, 1 long frame |
| interlace_en | input | 1 | Interlace enable |
| overscan_en | input | 1 | Tall picture select (later vblank start) |
| h_clk | output | H_W (11) | Master-clock position within the line |
| dot_idx | output | D_W (9) | Dot position within the line |
| v_line | output | V_W (9) | Line number |
| field | output | 1 | Field bit, toggles every frame |
| vblank | output | 1 | Vertical blanking flag |
| active | output | 1 | Visible picture flag |
| frame_start | output | 1 | One-clock strobe on the first clock of a frame |

## Verification
The bench builds the block with a miniature raster: 20 dots of 4 clocks per line, wide dots at positions 16 to 19, short-frame last line 13, long-frame last line 17, vblank starting at line 9 or 11, a shortened line at 11 and an active window from clock 8 to 56. This gives lines of 80, 84 and 88 clocks and frames of about 1200 clocks. Every combination of region, interlace and field, including both exception lines and the extra interlaced line, is then reached in about ten frames. Because the bench records the width of each dot, a misplaced wide dot or a wrong exception condition is detected directly.

// File: rtl/raster_pkg.sv
package raster_pkg;

  typedef enum logic [1:0] {
    LINE_NORMAL = 2'd0,
    LINE_SHORT  = 2'd1,
    LINE_LONG   = 2'd2
  } line_kind_e;

  typedef struct packed {
    logic pal;
    logic interlace;
    logic tall;
  } raster_cfg_t;

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount
  import raster_pkg::*;
#(
  parameter int DOT_CLKS   = 4,
  parameter int LINE_DOTS  = 340,
  parameter int WIDE_FIRST = 323,
  parameter int WIDE_CNT   = 4,
  parameter int H_W        = 11,
  parameter int D_W        = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  line_kind_e     kind,
  output logic [H_W-1:0] h_clk,
  output logic [D_W-1:0] dot_idx,
  output logic           line_end
);

  localparam int P_W        = $clog2(DOT_CLKS + 1);
  localparam int NORM_CLKS  = LINE_DOTS * DOT_CLKS + WIDE_CNT;
  localparam int SHORT_CLKS = LINE_DOTS * DOT_CLKS;
  localparam int LONG_CLKS  = NORM_CLKS + DOT_CLKS;

  localparam logic [P_W-1:0] PH_NARROW     = P_W'(DOT_CLKS - 1);
  localparam logic [P_W-1:0] PH_WIDE       = P_W'(DOT_CLKS);
  localparam logic [D_W-1:0] DOT_LAST_STD  = D_W'(LINE_DOTS - 1);
  localparam logic [D_W-1:0] DOT_LAST_LONG = D_W'(LINE_DOTS);

  logic [P_W-1:0] phase;
  logic [P_W-1:0] ph_top;
  logic [D_W-1:0] dot_last;
  logic           is_wide;
  logic           dot_done;

  // Wide-dot decode exists only when the parameters ask for wide dots.
  generate
    if (WIDE_CNT > 0) begin : g_wide
      localparam logic [D_W-1:0] WIDE_LO = D_W'(WIDE_FIRST);
      localparam logic [D_W-1:0] WIDE_HI = D_W'(WIDE_FIRST + WIDE_CNT);
      assign is_wide = (kind != LINE_SHORT) && (dot_idx >= WIDE_LO) && (dot_idx < WIDE_HI);
    end else begin : g_narrow
      assign is_wide = 1'b0;
    end
  endgenerate

  always_comb begin
    ph_top   = is_wide ? PH_WIDE : PH_NARROW;
    dot_last = (kind == LINE_LONG) ? DOT_LAST_LONG : DOT_LAST_STD;
    dot_done = (phase == ph_top);
    line_end = dot_done && (dot_idx == dot_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_clk   <= '0;
      dot_idx <= '0;
      phase   <= '0;
    end else if (line_end) begin
      h_clk   <= '0;
      dot_idx <= '0;
      phase   <= '0;
    end else begin
      h_clk <= h_clk + 1'b1;
      if (dot_done) begin
        dot_idx <= dot_idx + 1'b1;
        phase   <= '0;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  // Line lengths per kind
  p_norm_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && kind == LINE_NORMAL) |-> (h_clk == H_W'(NORM_CLKS - 1)));
  p_short_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && kind == LINE_SHORT) |-> (h_clk == H_W'(SHORT_CLKS - 1)));
  p_long_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && kind == LINE_LONG) |-> (h_clk == H_W'(LONG_CLKS - 1)));
  p_hstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> (h_clk == $past(h_clk) + 1'b1));
  p_hwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (h_clk == '0 && dot_idx == '0));

endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
  import raster_pkg::*;
#(
  parameter int NTSC_LAST  = 261,
  parameter int PAL_LAST   = 311,
  parameter int SHORT_LINE = 240,
  parameter int V_W        = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_end,
  input  raster_cfg_t    cfg_in,
  output logic [V_W-1:0] v_line,
  output logic           field,
  output raster_cfg_t    cfg,
  output line_kind_e     kind,
  output logic           frame_start
);

  localparam logic [V_W-1:0] NTSC_END = V_W'(NTSC_LAST);
  localparam logic [V_W-1:0] PAL_END  = V_W'(PAL_LAST);
  localparam logic [V_W-1:0] SHORT_V  = V_W'(SHORT_LINE);

  logic [V_W-1:0] v_last;
  logic           add_line;
  logic           frame_wrap;

  always_comb begin
    add_line   = cfg.interlace & ~field;
    v_last     = (cfg.pal ? PAL_END : NTSC_END) + {{(V_W-1){1'b0}}, add_line};
    frame_wrap = line_end && (v_line == v_last);
    if (!cfg.pal && !cfg.interlace && field && v_line == SHORT_V)
      kind = LINE_SHORT;
    else if (cfg.pal && cfg.interlace && field && v_line == PAL_END)
      kind = LINE_LONG;
    else
      kind = LINE_NORMAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_line      <= '0;
      field       <= 1'b0;
      cfg         <= '0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= frame_wrap;
      if (frame_wrap) begin
        v_line <= '0;
        field  <= ~field;
        cfg    <= cfg_in;
      end else if (line_end) begin
        v_line <= v_line + 1'b1;
      end
    end
  end

  p_vwrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (v_line == '0));
  p_vhold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(v_line));
  p_field_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (v_line == '0 && field != $past(field)));
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(cfg));

endmodule

// File: rtl/raster_flags.sv
module raster_flags #(
  parameter int VBL_START      = 225,
  parameter int VBL_START_TALL = 240,
  parameter int ACT_H_FIRST    = 88,
  parameter int ACT_H_END      = 1112,
  parameter int H_W            = 11,
  parameter int V_W            = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [H_W-1:0] h_clk,
  input  logic [V_W-1:0] v_line,
  input  logic           tall,
  output logic           vblank,
  output logic           active
);

  localparam logic [V_W-1:0] VB_NORM = V_W'(VBL_START);
  localparam logic [V_W-1:0] VB_TALL = V_W'(VBL_START_TALL);
  localparam logic [H_W-1:0] ACT_LO  = H_W'(ACT_H_FIRST);
  localparam logic [H_W-1:0] ACT_HI  = H_W'(ACT_H_END);

  logic [V_W-1:0] vb_line;
  logic           vis_line;

  always_comb begin
    vb_line  = tall ? VB_TALL : VB_NORM;
    vblank   = (v_line >= vb_line);
    vis_line = (v_line != '0) && !vblank;
    active   = vis_line && (h_clk >= ACT_LO) && (h_clk < ACT_HI);
  end

  p_active_unblank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (!vblank && v_line != '0));
  p_line0_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (v_line == '0) |-> (!vblank && !active));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int DOT_CLKS       = 4,
  parameter int LINE_DOTS      = 340,
  parameter int WIDE_FIRST     = 323,
  parameter int WIDE_CNT       = 4,
  parameter int ACT_H_FIRST    = 88,
  parameter int ACT_H_END      = 1112,
  parameter int NTSC_LAST      = 261,
  parameter int PAL_LAST       = 311,
  parameter int VBL_START      = 225,
  parameter int VBL_START_TALL = 240,
  parameter int SHORT_LINE     = 240,
  localparam int LONG_CLKS     = LINE_DOTS * DOT_CLKS + WIDE_CNT + DOT_CLKS,
  localparam int H_W           = $clog2(LONG_CLKS),
  localparam int D_W           = $clog2(LINE_DOTS + 1),
  localparam int V_TOP         = ((PAL_LAST > NTSC_LAST) ? PAL_LAST : NTSC_LAST) + 1,
  localparam int V_W           = $clog2(V_TOP + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pal_mode,
  input  logic           interlace_en,
  input  logic           overscan_en,
  output logic [H_W-1:0] h_clk,
  output logic [D_W-1:0] dot_idx,
  output logic [V_W-1:0] v_line,
  output logic           field,
  output logic           vblank,
  output logic           active,
  output logic           frame_start
);

  raster_cfg_t cfg_in;
  raster_cfg_t cfg;
  line_kind_e  kind;
  logic        line_end;

  assign cfg_in = '{pal: pal_mode, interlace: interlace_en, tall: overscan_en};

  raster_hcount #(
    .DOT_CLKS  (DOT_CLKS),
    .LINE_DOTS (LINE_DOTS),
    .WIDE_FIRST(WIDE_FIRST),
    .WIDE_CNT  (WIDE_CNT),
    .H_W       (H_W),
    .D_W       (D_W)
  ) u_h (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .h_clk   (h_clk),
    .dot_idx (dot_idx),
    .line_end(line_end)
  );

  raster_vcount #(
    .NTSC_LAST (NTSC_LAST),
    .PAL_LAST  (PAL_LAST),
    .SHORT_LINE(SHORT_LINE),
    .V_W       (V_W)
  ) u_v (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_end   (line_end),
    .cfg_in     (cfg_in),
    .v_line     (v_line),
    .field      (field),
    .cfg        (cfg),
    .kind       (kind),
    .frame_start(frame_start)
  );

  raster_flags #(
    .VBL_START     (VBL_START),
    .VBL_START_TALL(VBL_START_TALL),
    .ACT_H_FIRST   (ACT_H_FIRST),
    .ACT_H_END     (ACT_H_END),
    .H_W           (H_W),
    .V_W           (V_W)
  ) u_f (
    .clk   (clk),
    .rst_n (rst_n),
    .h_clk (h_clk),
    .v_line(v_line),
    .tall  (cfg.tall),
    .vblank(vblank),
    .active(active)
  );

endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;

  localparam int DOTS = 20;
  localparam int WLO  = 16;
  localparam int WN   = 4;
  localparam int AH0  = 8;
  localparam int AH1  = 56;
  localparam int NL   = 13;
  localparam int PL   = 17;
  localparam int VB   = 9;
  localparam int VBT  = 11;
  localparam int SHL  = 11;
  localparam int HW   = $clog2(DOTS*4 + WN + 4);
  localparam int DW   = $clog2(DOTS + 1);
  localparam int VW   = $clog2(PL + 2);

  logic clk = 0;
  logic rst_n = 0;
  logic pal_mode = 0, interlace_en = 0, overscan_en = 0;
  logic [HW-1:0] h_clk;
  logic [DW-1:0] dot_idx;
  logic [VW-1:0] v_line;
  logic field, vblank, active, frame_start;

  int tests = 0;
  int fails = 0;
  int line_len [0:31];
  int line_dots[0:31];
  int dw [0:31][0:31];
  int nlines, flag_err, h_err, frm_field;

  always #2.5 clk = ~clk;

  raster_timing_gen #(
    .DOT_CLKS(4), .LINE_DOTS(DOTS), .WIDE_FIRST(WLO), .WIDE_CNT(WN),
    .ACT_H_FIRST(AH0), .ACT_H_END(AH1), .NTSC_LAST(NL), .PAL_LAST(PL),
    .VBL_START(VB), .VBL_START_TALL(VBT), .SHORT_LINE(SHL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .interlace_en(interlace_en),
    .overscan_en(overscan_en), .h_clk(h_clk), .dot_idx(dot_idx), .v_line(v_line),
    .field(field), .vblank(vblank), .active(active), .frame_start(frame_start)
  );

  task automatic summary_and_end();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary_and_end();
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected per-dot width: wide dots only on non-short lines inside the wide window
  task automatic check_widths(input string req, input int v, input bit short_line);
    int bad = 0;
    for (int d = 0; d < line_dots[v]; d++) begin
      int e = (!short_line && d >= WLO && d < WLO + WN) ? 5 : 4;
      if (dw[v][d] != e) bad++;
    end
    check(req, $sformatf("dot width mismatches on line %0d", v), bad, 0);
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start);
  endtask

  // Entered at a negedge with frame_start high; returns at the next such negedge.
  task automatic measure_frame(input int vbs);
    int cyc = 0;
    int prev_h = -1;
    for (int i = 0; i < 32; i++) begin
      line_len[i] = 0; line_dots[i] = 0;
      for (int j = 0; j < 32; j++) dw[i][j] = 0;
    end
    nlines = 0; flag_err = 0; h_err = 0; frm_field = field;
    do begin
      int v = v_line;
      int h = h_clk;
      bit evb = (v >= vbs);
      bit eact = (v >= 1) && (v < vbs) && (h >= AH0) && (h < AH1);
      line_len[v]++;
      dw[v][dot_idx]++;
      if (dot_idx + 1 > line_dots[v]) line_dots[v] = dot_idx + 1;
      if (vblank !== evb || active !== eact) flag_err++;
      if (h == 0) nlines++;
      else if (h != prev_h + 1) h_err++;
      prev_h = h;
      @(negedge clk);
      cyc++;
    end while (!frame_start && cyc < 5000);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1", "h_clk in reset", h_clk, 0);
    check("R1", "dot_idx in reset", dot_idx, 0);
    check("R1", "v_line in reset", v_line, 0);
    check("R1", "field in reset", field, 0);
    check("R1", "vblank/active/frame_start in reset", {vblank, active, frame_start}, 0);
    rst_n = 1;
  endtask

  task automatic t_ntsc_prog_f1();
    measure_frame(VB);
    check("R6", "field of first full frame", frm_field, 1);
    check("R5", "lines short-frame progressive", nlines, NL + 1);
    check("R2", "normal line length", line_len[2], DOTS*4 + WN);
    check("R2", "normal line dots", line_dots[2], DOTS);
    check_widths("R2", 2, 0);
    check("R2", "h steps by one", h_err, 0);
    check("R3", "short line length", line_len[SHL], DOTS*4);
    check("R3", "short line dots", line_dots[SHL], DOTS);
    check_widths("R3", SHL, 1);
    check("R7_R8", "flag mismatches normal height", flag_err, 0);
  endtask

  task automatic t_ntsc_prog_f0();
    overscan_en = 1;
    measure_frame(VB);
    check("R6", "field toggles", frm_field, 0);
    check("R3", "no short line when field=0", line_len[SHL], DOTS*4 + WN);
    check("R9", "overscan change deferred", flag_err, 0);
  endtask

  task automatic t_tall_f1();
    pal_mode = 1; interlace_en = 1;
    measure_frame(VBT);
    check("R7", "flag mismatches tall picture", flag_err, 0);
    check("R9", "region change deferred: lines", nlines, NL + 1);
    check("R9", "short line still present", line_len[SHL], DOTS*4);
  endtask

  task automatic t_pal_il_f0();
    measure_frame(VBT);
    check("R5", "lines long-frame interlace field0", nlines, PL + 2);
    check("R4", "no long line when field=0", line_len[PL], DOTS*4 + WN);
    check("R5", "extra line length", line_len[PL + 1], DOTS*4 + WN);
    check("R8", "flags long-frame", flag_err, 0);
  endtask

  task automatic t_pal_il_f1();
    pal_mode = 0;
    measure_frame(VBT);
    check("R5", "lines long-frame interlace field1", nlines, PL + 1);
    check("R4", "long line length", line_len[PL], DOTS*4 + WN + 4);
    check("R4", "long line dots", line_dots[PL], DOTS + 1);
    check_widths("R4", PL, 0);
  endtask

  task automatic t_ntsc_il();
    measure_frame(VBT);
    check("R5", "lines short-frame interlace field0", nlines, NL + 2);
    pal_mode = 1; interlace_en = 0; overscan_en = 0;
    measure_frame(VBT);
    check("R5", "lines short-frame interlace field1", nlines, NL + 1);
    check("R3", "no short line with interlace", line_len[SHL], DOTS*4 + WN);
  endtask

  task automatic t_pal_prog();
    measure_frame(VB);
    check("R5", "lines long-frame progressive field0", nlines, PL + 1);
    measure_frame(VB);
    check("R5", "lines long-frame progressive field1", nlines, PL + 1);
    check("R4", "no long line without interlace", line_len[PL], DOTS*4 + WN);
    check("R7", "flags after overscan off", flag_err, 0);
  endtask

  initial begin
    t_reset();
    wait_fs();
    check("R6", "frame_start at h=0 v=0", (h_clk == 0 && v_line == 0) ? 1 : 0, 1);
    t_ntsc_prog_f1();
    t_ntsc_prog_f0();
    t_tall_f1();
    t_pal_il_f0();
    t_pal_il_f1();
    t_ntsc_il();
    t_pal_prog();
    summary_and_end();
  end

endmodule